// File: doc/BRIEF.md
# Palette Colour Table Host Port

This block holds a colour lookup table of 256 entries. Each entry holds three 6-bit colour components, in the order red, green, blue. A host reaches the table through four byte-wide ports, chosen by a 2-bit select: write index, read index, component data and direction state. One component-position counter serves both directions.

For a write, the host loads the write index and then sends three component bytes. The bytes are held in a staging cache. The entry is written as a whole only when the third byte arrives, and the write index then steps to the next entry. For a read, the host loads the read index and then pulls component bytes one at a time. The read index steps after every third byte. A host can therefore stream any number of consecutive entries with a single index load.

A separate lookup port serves pixel logic. It returns the full 18-bit entry for any index, combinationally, at any time.

Top module: `pal_dac_port`

## Requirements
- R1: After reset, both indexes and the component position are 0. The direction state reads 0, and every table entry reads 0 on the lookup port.
- R2: A write to select 0 (write index) loads the write index from the low byte, returns the component position to 0 and sets the direction state to 0.
- R3: A write to select 1 (read index) loads the read index, returns the component position to 0 and sets the direction state to 3.
- R4: Each write to select 2 (data) stages one component in the slot given by the component position. The entry at the write index changes only on the third component. The entry is then written as {first, second, third}, with the first component in bits 17:12, and the write index increments.
- R5: Each read of select 2 returns the component, chosen by the component position, of the entry at the read index. After the third component the read index increments.
- R6: A read of select 3 returns the direction state. A write to select 3 has no effect.
- R7: Both indexes wrap from 255 to 0 when they advance.
- R8: Only the low 6 bits of a data byte are stored. Component reads return 0 in bits 7:6.
- R9: The lookup port is combinational in its index. A committed entry appears there in the cycle after the third data write, and not before.
- R10: The component position is shared between directions. A read-index load in the middle of a write sequence drops the staged components: the next data read returns component 0, and the target entry stays unchanged.
- R11: Reads of select 0 and select 1 return 0. The bus_rd and bus_wr strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe, one access per cycle |
| bus_rd | input | 1 | Host read strobe, one access per cycle |
| bus_sel | input | 2 | Port select: 0 write index, 1 read index, 2 data, 3 state |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte, valid while bus_rd is high |
| pix_idx | input | 8 | Lookup index from pixel logic |
| pix_rgb | output | 18 | Entry at pix_idx, {red, green, blue} |

## Verification
Two functions can land in the same cycle: the commit of a whole entry by the third data write, and a pixel lookup of that same entry. The bench points the lookup index at the target entry and drives the third data byte in one cycle. It requires the old value before the clock edge and the new value right after it. It then interleaves a read-index load with a half-finished write sequence. This shows that the shared position counter restarts the read at component 0 and that the staged bytes never reach the table.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
   typedef enum logic [1:0] {
      SEL_WIDX  = 2'd0,
      SEL_RIDX  = 2'd1,
      SEL_DATA  = 2'd2,
      SEL_STATE = 2'd3
   } dac_sel_e;

   localparam logic [1:0] DIR_WRITING = 2'd0;
   localparam logic [1:0] DIR_READING = 2'd3;
endpackage

// File: rtl/dac_seq.sv
module dac_seq #(
   parameter int IDX_W    = 8,
   parameter int NUM_COMP = 3,
   parameter int SUB_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_widx,
   input  logic             set_ridx,
   input  logic             data_wr,
   input  logic             data_rd,
   input  logic [IDX_W-1:0] idx_in,
   output logic [IDX_W-1:0] widx,
   output logic [IDX_W-1:0] ridx,
   output logic [SUB_W-1:0] sub,
   output logic [1:0]       dir,
   output logic             at_last
);
   import pal_dac_pkg::*;

   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(NUM_COMP - 1);

   assign at_last = (sub == SUB_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         widx <= '0;
         ridx <= '0;
         sub  <= '0;
         dir  <= DIR_WRITING;
      end else if (set_widx) begin
         widx <= idx_in;
         sub  <= '0;
         dir  <= DIR_WRITING;
      end else if (set_ridx) begin
         ridx <= idx_in;
         sub  <= '0;
         dir  <= DIR_READING;
      end else if (data_wr || data_rd) begin
         if (at_last) begin
            sub <= '0;
            if (data_wr) widx <= widx + 1'b1;
            else         ridx <= ridx + 1'b1;
         end else begin
            sub <= sub + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dac_stage.sv
module dac_stage #(
   parameter int COMP_W   = 6,
   parameter int NUM_COMP = 3,
   parameter int SUB_W    = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         data_wr,
   input  logic                         at_last,
   input  logic [SUB_W-1:0]             sub,
   input  logic [COMP_W-1:0]            comp_in,
   output logic                         commit,
   output logic [NUM_COMP*COMP_W-1:0]   commit_word
);
   logic [COMP_W-1:0] slot [NUM_COMP];

   assign commit = data_wr && at_last;

   for (genvar k = 0; k < NUM_COMP; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[k] <= '0;
         else if (data_wr && sub == SUB_W'(k))
            slot[k] <= comp_in;
      end
      if (k == NUM_COMP - 1) begin : g_tail
         assign commit_word[(NUM_COMP-1-k)*COMP_W +: COMP_W] = comp_in;
      end else begin : g_held
         assign commit_word[(NUM_COMP-1-k)*COMP_W +: COMP_W] = slot[k];
      end
   end
endmodule

// File: rtl/dac_ram.sv
module dac_ram #(
   parameter int IDX_W          = 8,
   parameter int WORD_W         = 18,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [WORD_W-1:0] wword,
   input  logic [IDX_W-1:0]  host_addr,
   output logic [WORD_W-1:0] host_word,
   input  logic [IDX_W-1:0]  pix_addr,
   output logic [WORD_W-1:0] pix_word
);
   localparam int DEPTH = 1 << IDX_W;

   logic [WORD_W-1:0] mem [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[e] <= '0;
            else if (we && waddr == IDX_W'(e))
               mem[e] <= wword;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we && waddr == IDX_W'(e))
               mem[e] <= wword;
         end
      end
   end

   assign host_word = mem[host_addr];
   assign pix_word  = mem[pix_addr];
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port #(
   parameter int IDX_W          = 8,
   parameter int COMP_W         = 6,
   parameter int NUM_COMP       = 3,
   parameter int BUS_W          = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_wr,
   input  logic                       bus_rd,
   input  logic [1:0]                 bus_sel,
   input  logic [BUS_W-1:0]           bus_wdata,
   output logic [BUS_W-1:0]           bus_rdata,
   input  logic [IDX_W-1:0]           pix_idx,
   output logic [NUM_COMP*COMP_W-1:0] pix_rgb
);
   import pal_dac_pkg::*;

   localparam int SUB_W  = (NUM_COMP > 1) ? $clog2(NUM_COMP) : 1;
   localparam int WORD_W = NUM_COMP * COMP_W;

   if (COMP_W > BUS_W) begin : g_bad_comp
      $error("COMP_W must fit in BUS_W");
   end
   if (IDX_W > BUS_W) begin : g_bad_idx
      $error("IDX_W must fit in BUS_W");
   end
   if (NUM_COMP < 2) begin : g_bad_num
      $error("NUM_COMP must be at least 2");
   end

   logic             set_widx, set_ridx, data_wr, data_rd;
   logic [IDX_W-1:0] widx, ridx;
   logic [SUB_W-1:0] sub;
   logic [1:0]       dir;
   logic             at_last;
   logic             commit;
   logic [WORD_W-1:0] commit_word, host_word;
   logic [COMP_W-1:0] host_comp;

   assign set_widx = bus_wr && (bus_sel == SEL_WIDX);
   assign set_ridx = bus_wr && (bus_sel == SEL_RIDX);
   assign data_wr  = bus_wr && (bus_sel == SEL_DATA);
   assign data_rd  = bus_rd && (bus_sel == SEL_DATA);

   dac_seq #(.IDX_W(IDX_W), .NUM_COMP(NUM_COMP), .SUB_W(SUB_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .set_widx(set_widx), .set_ridx(set_ridx),
      .data_wr(data_wr), .data_rd(data_rd),
      .idx_in(bus_wdata[IDX_W-1:0]),
      .widx(widx), .ridx(ridx), .sub(sub), .dir(dir), .at_last(at_last)
   );

   dac_stage #(.COMP_W(COMP_W), .NUM_COMP(NUM_COMP), .SUB_W(SUB_W)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .data_wr(data_wr), .at_last(at_last), .sub(sub),
      .comp_in(bus_wdata[COMP_W-1:0]),
      .commit(commit), .commit_word(commit_word)
   );

   dac_ram #(.IDX_W(IDX_W), .WORD_W(WORD_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_ram (
      .clk(clk), .rst_n(rst_n),
      .we(commit), .waddr(widx), .wword(commit_word),
      .host_addr(ridx), .host_word(host_word),
      .pix_addr(pix_idx), .pix_word(pix_rgb)
   );

   always_comb begin
      host_comp = '0;
      for (int k = 0; k < NUM_COMP; k++) begin
         if (sub == SUB_W'(k))
            host_comp = host_word[(NUM_COMP-1-k)*COMP_W +: COMP_W];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (bus_sel)
            SEL_DATA:  bus_rdata = BUS_W'(host_comp);
            SEL_STATE: bus_rdata = BUS_W'(dir);
            default:   bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/pal_dac_port_chk.sv
module pal_dac_port_chk #(
   parameter int IDX_W    = 8,
   parameter int COMP_W   = 6,
   parameter int NUM_COMP = 3,
   parameter int BUS_W    = 8,
   parameter int SUB_W    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic             bus_rd,
   input logic [1:0]       bus_sel,
   input logic [BUS_W-1:0] bus_wdata,
   input logic [BUS_W-1:0] bus_rdata,
   input logic [IDX_W-1:0] widx,
   input logic [IDX_W-1:0] ridx,
   input logic [SUB_W-1:0] sub,
   input logic [1:0]       dir
);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(NUM_COMP - 1);

   // R2
   widx_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == 2'd0) |=>
         (widx == $past(bus_wdata[IDX_W-1:0]) && sub == '0 && dir == 2'd0));

   // R3
   ridx_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == 2'd1) |=>
         (ridx == $past(bus_wdata[IDX_W-1:0]) && sub == '0 && dir == 2'd3));

   // R4
   commit_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == 2'd2 && sub == SUB_LAST) |=>
         (widx == IDX_W'($past(widx) + 1'b1) && sub == '0));

   // R4
   stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == 2'd2 && sub != SUB_LAST) |=>
         (widx == $past(widx) && sub == SUB_W'($past(sub) + 1'b1)));

   // R5
   read_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_sel == 2'd2 && sub == SUB_LAST) |=>
         (ridx == IDX_W'($past(ridx) + 1'b1) && sub == '0));

   // R6
   state_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == 2'd3) |=> ($stable(dir) && $stable(sub) && $stable(widx) && $stable(ridx)));

   // R8
   rdata_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_sel == 2'd2) |-> (bus_rdata >> COMP_W) == '0);

   // R10
   sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sub <= SUB_LAST);

   // R11
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));
endmodule

bind pal_dac_port pal_dac_port_chk #(
   .IDX_W(IDX_W), .COMP_W(COMP_W), .NUM_COMP(NUM_COMP), .BUS_W(BUS_W), .SUB_W(SUB_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .widx(widx), .ridx(ridx), .sub(sub), .dir(dir)
);

// File: tb/tb_pal_dac_port.sv
module tb_pal_dac_port;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [1:0]  bus_sel = 2'd0;
   logic [7:0]  bus_wdata = 8'd0;
   logic [7:0]  bus_rdata;
   logic [7:0]  pix_idx = 8'd0;
   logic [17:0] pix_rgb;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   pal_dac_port dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pix_idx(pix_idx), .pix_rgb(pix_rgb)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [17:0] pack(input logic [7:0] a, b, c);
      return {a[5:0], b[5:0], c[5:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] sel, output logic [7:0] d);
      @(negedge clk);
      bus_sel = sel; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_rd = 1'b0;
   endtask

   task automatic pix_check(input string req, input logic [7:0] idx, input logic [17:0] exp);
      @(negedge clk);
      pix_idx = idx;
      #1 check(req, 32'(pix_rgb), 32'(exp));
   endtask

   task automatic t_reset;
      logic [7:0] v;
      bus_read(2'd3, v);   check("R1 state", 32'(v), 32'd0);
      bus_read(2'd2, v);   check("R1 data", 32'(v), 32'd0);
      pix_check("R1 entry0", 8'd0, 18'd0);
      pix_check("R1 entry255", 8'd255, 18'd0);
   endtask

   task automatic t_commit;
      bus_write(2'd0, 8'd5);
      bus_write(2'd2, 8'h11);
      pix_check("R4 staged1", 8'd5, 18'd0);
      bus_write(2'd2, 8'h22);
      pix_check("R4 staged2", 8'd5, 18'd0);
      @(negedge clk);
      pix_idx = 8'd5; bus_sel = 2'd2; bus_wdata = 8'h33; bus_wr = 1'b1;
      #1 check("R9 before commit", 32'(pix_rgb), 32'd0);
      @(posedge clk);
      #1 bus_wr = 1'b0;
      check("R9 after commit", 32'(pix_rgb), 32'(pack(8'h11, 8'h22, 8'h33)));
      bus_write(2'd2, 8'h01);
      bus_write(2'd2, 8'h02);
      bus_write(2'd2, 8'h03);
      pix_check("R4 next entry", 8'd6, pack(8'h01, 8'h02, 8'h03));
   endtask

   task automatic t_readback;
      logic [7:0] v;
      logic [7:0] exp [6] = '{8'h11, 8'h22, 8'h33, 8'h01, 8'h02, 8'h03};
      bus_write(2'd1, 8'd5);
      bus_read(2'd3, v);   check("R3 state", 32'(v), 32'd3);
      for (int i = 0; i < 6; i++) begin
         bus_read(2'd2, v);
         check("R5 component", 32'(v), 32'(exp[i]));
      end
   endtask

   task automatic t_mask;
      logic [7:0] v;
      bus_write(2'd0, 8'd10);
      bus_write(2'd2, 8'hFF);
      bus_write(2'd2, 8'hC0);
      bus_write(2'd2, 8'h7F);
      pix_check("R8 stored", 8'd10, pack(8'h3F, 8'h00, 8'h3F));
      bus_write(2'd1, 8'd10);
      bus_read(2'd2, v);   check("R8 read0", 32'(v), 32'h3F);
      bus_read(2'd2, v);   check("R8 read1", 32'(v), 32'h00);
      bus_read(2'd2, v);   check("R8 read2", 32'(v), 32'h3F);
   endtask

   task automatic t_wrap;
      logic [7:0] v;
      logic [7:0] exp [6] = '{8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F};
      bus_write(2'd0, 8'd255);
      for (int i = 0; i < 6; i++) bus_write(2'd2, exp[i]);
      pix_check("R7 entry255", 8'd255, pack(8'h0A, 8'h0B, 8'h0C));
      pix_check("R7 entry0", 8'd0, pack(8'h0D, 8'h0E, 8'h0F));
      bus_write(2'd1, 8'd255);
      for (int i = 0; i < 6; i++) begin
         bus_read(2'd2, v);
         check("R7 read wrap", 32'(v), 32'(exp[i]));
      end
   endtask

   task automatic t_state;
      logic [7:0] v;
      bus_write(2'd1, 8'd0);
      bus_write(2'd3, 8'h00);
      bus_read(2'd3, v);   check("R6 write ignored (3)", 32'(v), 32'd3);
      bus_write(2'd0, 8'd0);
      bus_read(2'd3, v);   check("R2 state", 32'(v), 32'd0);
      bus_write(2'd3, 8'hFF);
      bus_read(2'd3, v);   check("R6 write ignored (0)", 32'(v), 32'd0);
      bus_read(2'd0, v);   check("R11 widx port read", 32'(v), 32'd0);
      bus_read(2'd1, v);   check("R11 ridx port read", 32'(v), 32'd0);
   endtask

   task automatic t_shared;
      logic [7:0] v;
      bus_write(2'd0, 8'd20);
      bus_write(2'd2, 8'h05);
      bus_write(2'd2, 8'h06);
      bus_write(2'd1, 8'd5);
      bus_read(2'd2, v);   check("R10 restart at comp0", 32'(v), 32'h11);
      pix_check("R10 entry untouched", 8'd20, 18'd0);
      bus_write(2'd0, 8'd20);
      bus_write(2'd2, 8'h07);
      bus_write(2'd2, 8'h08);
      bus_write(2'd2, 8'h09);
      pix_check("R2 fresh sequence", 8'd20, pack(8'h07, 8'h08, 8'h09));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_commit();
      t_readback();
      t_mask();
      t_wrap();
      t_state();
      t_shared();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule